// File: doc/BRIEF.md
# Idle Timeout Power State Controller

This block is an always-on supervisor that watches a subsystem for signs of use and lowers its power state in steps as the idle time grows. A counter advances on each pulse of a slow time-base tick and returns to zero on any activity pulse. Three programmable thresholds divide the idle count into four levels: fully active, dimmed, display dark and asleep. The block drives an encoded state and one enable per stage, and the enables are nested, so a deeper stage keeps the shallower ones asserted.

Software reaches the block through a plain register port. The port has a write strobe, an address and write data, and its read data is combinational. Software can retune the three thresholds, but a write that would break their ascending order is dropped. Software can also pin the state to a chosen level with a force register, and it can read the current state together with a sticky wake flag. The flag records that activity arrived while the subsystem was in a low-power level, and writing 1 to its bit clears it.

When the attached device is reported absent, the block goes straight to sleep and does not wait for any timeout. The controller itself never powers down, so it can always see new activity and bring the subsystem back.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset, the state is active (0), all three enables are low, the thresholds read 10, 20 and 120, the force register reads 0 and the wake flag is 0.
- R2: The idle count rises by one on each clock edge that sees `tick` high and no activity. It saturates at all-ones and never wraps back to a smaller value.
- R3: With the device present and force off, the next state is the deepest stage whose threshold is at or below the updated idle count. The encoding is 0 active, 1 dim, 2 dark and 3 sleep, and the state register takes this value on the same edge that moves the count.
- R4: An activity pulse clears the idle count and makes the state active on the next edge, provided the device is present and force is off.
- R5: `dim_en` is high in states 1 to 3, `dark_en` is high in states 2 and 3, and `sleep_en` is high only in state 3.
- R6: While `dev_present` is low, the state becomes sleep (3) on the next edge. This overrides the timer, activity and force.
- R7: While the force enable (bit 0 of address 3) is set and the device is present, the state follows the forced value (bits 2:1 of address 3). This overrides the timer and activity.
- R8: A write to a threshold is accepted only if the new value is at or above the next shallower threshold and at or below the next deeper one. A write that fails this test leaves the register unchanged.
- R9: Register map. Addresses 0, 1 and 2 hold the dim, dark and sleep thresholds. Address 3 is the force register: bit 0 is the enable and bits 2:1 are the forced state. Address 4 is status: bits 1:0 are the current state and bit 2 is the wake flag. Any other address reads as 0.
- R10: The wake flag is set on an edge where activity is seen while the state is not active. Writing 1 to bit 2 of address 4 clears it. If a set and a clear happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_pulse | input | 1 | Activity seen this cycle |
| tick | input | 1 | One-cycle pulse from the slow time base |
| dev_present | input | 1 | High while the attached device is present |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | DW (16) | Register write data |
| reg_rdata | output | DW (16) | Combinational read data for `reg_addr` |
| pwr_state | output | 2 | Encoded power state |
| dim_en | output | 1 | Dim stage enable |
| dark_en | output | 1 | Display-off stage enable |
| sleep_en | output | 1 | Sleep stage enable |

## Verification
Every state effect shows up one clock after the edge that sees its cause: ticks, activity, absence of the device, and a force value that is already registered. A force write needs two edges, one to load the register and one to move the state. A register write is visible on `reg_rdata` right after its edge, and a read returns data within the same cycle as the address. The bench changes inputs just after a rising edge, advances its behavioural model on that edge, and compares at the falling edge. Directed checks are placed at the exact tick counts where a threshold is crossed, and at the saturation limit.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_DIM    = 2'd1,
    PS_DARK   = 2'd2,
    PS_SLEEP  = 2'd3
  } pstate_e;

  localparam int NSTG    = 3;
  localparam int A_FORCE = 3;
  localparam int A_STAT  = 4;
  localparam int B_FEN   = 0;
  localparam int B_WAKE  = 2;
endpackage

// File: rtl/psc_idle_counter.sv
module psc_idle_counter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          tick,
  output logic [TW-1:0] cnt_q,
  output logic [TW-1:0] cnt_d
);
  localparam logic [TW-1:0] CMAX = '1;

  always_comb begin
    cnt_d = cnt_q;
    if (act)
      cnt_d = '0;
    else if (tick && (cnt_q != CMAX))
      cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psc_stage_select.sv
module psc_stage_select
  import psc_pkg::*;
#(
  parameter int TW = 16,
  parameter int NS = NSTG
) (
  input  logic [TW-1:0]    cnt,
  input  logic [NS*TW-1:0] thr,
  output pstate_e          stage
);
  logic [NS-1:0] hit;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign hit[g] = (cnt >= thr[g*TW +: TW]);
  end

  always_comb begin
    stage = PS_ACTIVE;
    for (int i = 0; i < NS; i++)
      if (hit[i]) stage = pstate_e'(2'(i + 1));
  end
endmodule

// File: rtl/psc_regs.sv
module psc_regs
  import psc_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int NS = NSTG,
  parameter logic [NS*TW-1:0] THR_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  pstate_e         state,
  input  logic            act,
  output logic [NS*TW-1:0] thr,
  output logic            force_en,
  output pstate_e         force_st,
  output logic            wake,
  output logic [DW-1:0]   rdata
);
  logic [TW-1:0] wv;
  logic [NS-1:0] lo_ok, hi_ok, sel;

  assign wv = wdata[TW-1:0];

  for (genvar g = 0; g < NS; g++) begin : g_thr
    assign sel[g] = wr && (addr == AW'(g));
    if (g == 0) begin : g_lo0
      assign lo_ok[g] = 1'b1;
    end else begin : g_lo
      assign lo_ok[g] = (wv >= thr[(g-1)*TW +: TW]);
    end
    if (g == NS - 1) begin : g_hiN
      assign hi_ok[g] = 1'b1;
    end else begin : g_hi
      assign hi_ok[g] = (wv <= thr[(g+1)*TW +: TW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr[g*TW +: TW] <= THR_RST[g*TW +: TW];
      else if (sel[g] && lo_ok[g] && hi_ok[g])
        thr[g*TW +: TW] <= wv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_en <= 1'b0;
      force_st <= PS_ACTIVE;
    end else if (wr && (addr == AW'(A_FORCE))) begin
      force_en <= wdata[B_FEN];
      force_st <= pstate_e'(wdata[B_FEN+2:B_FEN+1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wake <= 1'b0;
    else if (act && (state != PS_ACTIVE))
      wake <= 1'b1;
    else if (wr && (addr == AW'(A_STAT)) && wdata[B_WAKE])
      wake <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NS; i++)
      if (addr == AW'(i)) rdata[TW-1:0] = thr[i*TW +: TW];
    if (addr == AW'(A_FORCE)) rdata[2:0] = {force_st, force_en};
    if (addr == AW'(A_STAT))  rdata[2:0] = {wake, state};
  end
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import psc_pkg::*;
#(
  parameter int TW        = 16,
  parameter int DW        = 16,
  parameter int AW        = 3,
  parameter int DEF_DIM   = 10,
  parameter int DEF_DARK  = 20,
  parameter int DEF_SLEEP = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_pulse,
  input  logic          tick,
  input  logic          dev_present,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    pwr_state,
  output logic          dim_en,
  output logic          dark_en,
  output logic          sleep_en
);
  localparam logic [NSTG*TW-1:0] THR_RST =
    {TW'(DEF_SLEEP), TW'(DEF_DARK), TW'(DEF_DIM)};

  logic [TW-1:0]      cnt_q, cnt_d;
  logic [NSTG*TW-1:0] thr;
  logic               force_en, wake_q;
  pstate_e            force_st, tmr_stage, state_q, state_d;

  psc_idle_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act(act_pulse), .tick(tick),
    .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  psc_stage_select #(.TW(TW), .NS(NSTG)) u_sel (
    .cnt(cnt_d), .thr(thr), .stage(tmr_stage)
  );

  psc_regs #(.TW(TW), .DW(DW), .AW(AW), .NS(NSTG), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .state(state_q), .act(act_pulse), .thr(thr), .force_en(force_en),
    .force_st(force_st), .wake(wake_q), .rdata(reg_rdata)
  );

  always_comb begin
    if (!dev_present)   state_d = PS_SLEEP;
    else if (force_en)  state_d = force_st;
    else if (act_pulse) state_d = PS_ACTIVE;
    else                state_d = tmr_stage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_ACTIVE;
    else        state_q <= state_d;
  end

  assign pwr_state = state_q;
  assign dim_en    = (state_q != PS_ACTIVE);
  assign dark_en   = (state_q == PS_DARK) || (state_q == PS_SLEEP);
  assign sleep_en  = (state_q == PS_SLEEP);
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_pulse,
  input logic          tick,
  input logic          dev_present,
  input logic [1:0]    pwr_state,
  input logic          dim_en,
  input logic          dark_en,
  input logic          sleep_en,
  input logic          force_en,
  input logic [1:0]    force_st,
  input logic          wake,
  input logic [TW-1:0] cnt,
  input logic [3*TW-1:0] thr
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_pulse && !tick) |=> $stable(cnt));

  // R4
  act_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && dev_present && !force_en) |=> (pwr_state == 2'd0));

  // R5
  enable_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_en |-> (dark_en && dim_en)) and (dark_en |-> dim_en));

  // R6
  absent_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_present |=> (pwr_state == 2'd3));

  // R7
  force_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_present && force_en) |=> (pwr_state == $past(force_st)));

  // R8
  thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr[TW-1:0] <= thr[2*TW-1:TW]) && (thr[2*TW-1:TW] <= thr[3*TW-1:2*TW]));

  // R10
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && (pwr_state != 2'd0)) |=> wake);
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .tick(tick),
  .dev_present(dev_present), .pwr_state(pwr_state), .dim_en(dim_en),
  .dark_en(dark_en), .sleep_en(sleep_en), .force_en(force_en),
  .force_st(force_st), .wake(wake_q), .cnt(cnt_q), .thr(thr)
);

// File: tb/sim_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_idle_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_pulse = 1'b0, tick = 1'b0, dev_present = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  pwr_state;
  logic        dim_en, dark_en, sleep_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string ph = "R1";

  int m_cnt, m_st, m_fen, m_fst, m_wake;
  int m_thr[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_pwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .tick(tick),
    .dev_present(dev_present), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_state(pwr_state),
    .dim_en(dim_en), .dark_en(dark_en), .sleep_en(sleep_en)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_fen = 0; m_fst = 0; m_wake = 0;
      m_thr[0] = 10; m_thr[1] = 20; m_thr[2] = 120;
    end else begin
      int nc, ts, ns, nw, v;
      nc = act_pulse ? 0 : ((tick && m_cnt < CMAX) ? m_cnt + 1 : m_cnt);
      ts = 0;
      for (int i = 0; i < 3; i++) if (nc >= m_thr[i]) ts = i + 1;
      ns = !dev_present ? 3 : (m_fen != 0) ? m_fst : act_pulse ? 0 : ts;
      if (act_pulse && m_st != 0) nw = 1;
      else if (reg_wr && reg_addr == 4 && reg_wdata[2]) nw = 0;
      else nw = m_wake;
      if (reg_wr) begin
        v = int'(reg_wdata);
        case (reg_addr)
          3'd0: if (v <= m_thr[1]) m_thr[0] = v;
          3'd1: if (v >= m_thr[0] && v <= m_thr[2]) m_thr[1] = v;
          3'd2: if (v >= m_thr[1]) m_thr[2] = v;
          3'd3: begin m_fen = int'(reg_wdata[0]); m_fst = int'(reg_wdata[2:1]); end
          default: ;
        endcase
      end
      m_cnt = nc; m_st = ns; m_wake = nw;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0, 1, 2: return m_thr[a];
      3:       return m_fst * 2 + m_fen;
      4:       return m_wake * 4 + m_st;
      default: return 0;
    endcase
  endfunction

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ph, "pwr_state", int'(pwr_state), m_st);
      check("R5", "enables", int'({dim_en, dark_en, sleep_en}),
            (m_st >= 1 ? 4 : 0) + (m_st >= 2 ? 2 : 0) + (m_st == 3 ? 1 : 0));
      check("R9", "reg_rdata", int'(reg_rdata), exp_rd(int'(reg_addr)));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1'b1; step(); end
    tick = 1'b0;
  endtask

  task automatic pulse();
    act_pulse = 1'b1; step(); act_pulse = 1'b0;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 3'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int d;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "state in reset", int'(pwr_state), 0);
    check("R1", "enables in reset", int'({dim_en, dark_en, sleep_en}), 0);
    rst_n = 1'b1;
    step();
    rd(0, d); check("R1", "dim threshold", d, 10);
    rd(1, d); check("R1", "dark threshold", d, 20);
    rd(2, d); check("R1", "sleep threshold", d, 120);
    rd(3, d); check("R1", "force reg", d, 0);
    rd(4, d); check("R1", "status", d, 0);

    // R9: unmapped addresses
    ph = "R9";
    rd(5, d); check("R9", "unmapped 5", d, 0);
    rd(7, d); check("R9", "unmapped 7", d, 0);

    // R3: escalating stages at default thresholds
    ph = "R3";
    ticks(9);   check("R3", "after 9 ticks", int'(pwr_state), 0);
    ticks(1);   check("R3", "after 10 ticks", int'(pwr_state), 1);
    ticks(9);   check("R3", "after 19 ticks", int'(pwr_state), 1);
    ticks(1);   check("R3", "after 20 ticks", int'(pwr_state), 2);
    ticks(99);  check("R3", "after 119 ticks", int'(pwr_state), 2);
    ticks(1);   check("R3", "after 120 ticks", int'(pwr_state), 3);

    // R4 and R10: activity wakes, sets the sticky flag, write-1 clears
    ph = "R4";
    pulse();    check("R4", "state after activity", int'(pwr_state), 0);
    rd(4, d);   check("R10", "wake flag set", d, 4);
    wr(4, 4);   rd(4, d); check("R10", "wake flag cleared", d, 0);
    ticks(9);   check("R4", "count restarted", int'(pwr_state), 0);
    ticks(1);   check("R3", "dim after restart", int'(pwr_state), 1);
    ph = "R10";
    act_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'd4;
    step();
    act_pulse = 1'b0; reg_wr = 1'b0;
    rd(4, d);   check("R10", "set wins over clear", d, 4);
    wr(4, 4);

    // R8: ordered threshold writes
    ph = "R8";
    wr(0, 4); wr(1, 6); wr(2, 8);
    rd(0, d); check("R8", "dim accepted", d, 4);
    rd(1, d); check("R8", "dark accepted", d, 6);
    wr(0, 7); rd(0, d); check("R8", "dim above dark rejected", d, 4);
    wr(2, 5); rd(2, d); check("R8", "sleep below dark rejected", d, 8);
    wr(1, 9); rd(1, d); check("R8", "dark above sleep rejected", d, 6);
    ph = "R3";
    pulse();
    ticks(4);   check("R3", "new dim threshold", int'(pwr_state), 1);
    ticks(2);   check("R3", "new dark threshold", int'(pwr_state), 2);
    ticks(2);   check("R3", "new sleep threshold", int'(pwr_state), 3);

    // R7: software force
    ph = "R7";
    pulse();
    wr(3, 3);   rd(3, d); check("R9", "force readback", d, 3);
    step();     check("R7", "forced dim", int'(pwr_state), 1);
    pulse();    check("R7", "activity ignored under force", int'(pwr_state), 1);
    ticks(10);  check("R7", "timer ignored under force", int'(pwr_state), 1);
    wr(3, 0);
    pulse();    check("R7", "released", int'(pwr_state), 0);

    // R6: device absent overrides everything
    ph = "R6";
    wr(3, 5);
    dev_present = 1'b0; step();
    check("R6", "absent forces sleep", int'(pwr_state), 3);
    act_pulse = 1'b1; step(); act_pulse = 1'b0;
    check("R6", "absent beats activity and force", int'(pwr_state), 3);
    wr(3, 0);
    dev_present = 1'b1;
    pulse();    check("R6", "present again, active", int'(pwr_state), 0);
    wr(4, 4);

    // R2: counter saturation, no wrap
    ph = "R2";
    wr(2, CMAX); wr(1, CMAX - 1); wr(0, CMAX - 2);
    pulse();
    ticks(CMAX - 3); check("R2", "one below dim", int'(pwr_state), 0);
    ticks(1);        check("R2", "dim at count max-2", int'(pwr_state), 1);
    ticks(2);        check("R2", "sleep at count max", int'(pwr_state), 3);
    ticks(20);       check("R2", "saturated, no wrap", int'(pwr_state), 3);
    step();

    finish_up();
  end
endmodule